// File: doc/BRIEF.md
# Accumulator ALU Flag and Status Register Unit

This unit produces the condition flags of an 8-bit accumulator ALU and holds the status byte that software reads. Each cycle it receives an accumulator operand, a file operand, an operation code, a bit index and a flag saying whether the status byte is the destination. It returns the 8-bit result at once, and on the clock edge that completes a valid operation it updates the zero, digit-carry and carry bits.

The unit also keeps two reset-status bits, time-out and power-down. Only event inputs move these bits: a watchdog clear, entry into sleep and a watchdog expiry. When an instruction names the status byte as its destination, the file operand is the status byte itself. Operations that produce flags cannot overwrite the arithmetic bits through the destination write. Bit-set, bit-clear, nibble-swap, accumulator-move and pass operations can write the three low bits freely.

Status byte layout: bit 0 carry (C), bit 1 digit carry (DC), bit 2 zero (Z), bit 3 power-down (PD), bit 4 time-out (TO), bits 7..5 always zero. Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 clear, 6 rotate left through carry, 7 rotate right through carry, 8 bit set, 9 bit clear, 10 nibble swap, 11 move accumulator, 12..15 pass file operand.

Top module: `sr_status_unit`

## Requirements
- R1: While reset is asserted the status byte reads 0x18: TO=1, PD=1, Z=DC=C=0.
- R2: Bits 7..5 of the status byte always read zero, including after a write of 0xFF to the status byte.
- R3: Add (code 0): result = (file + acc) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z=1 exactly when the result is zero.
- R4: Subtract (code 1): result = (file - acc) mod 256, computed as file + ~acc + 1. C=1 when file >= acc and DC=1 when file[3:0] >= acc[3:0], so each reads 1 when no borrow occurs. Z follows the result.
- R5: Rotate left (code 6) gives {file[6:0], C} and loads C with file[7]. Rotate right (code 7) gives {C, file[7:1]} and loads C with file[0]. Z and DC are unchanged.
- R6: AND, OR, XOR and clear (codes 2..5) update only Z. DC and C keep their values, and clear yields result 0.
- R7: The status byte changes only on a clock edge where op_valid is high or an event input is high. With op_valid low, Z, DC and C hold.
- R8: When a flag-producing operation (codes 0..7) has the status byte as its destination, the written value is discarded and only the computed flags change. Clearing the status byte therefore yields 000u_u1uu.
- R9: Codes 8..15 never alter flags. With the status byte as destination, they write result[2:0] into C, DC and Z and leave TO and PD unchanged. With another destination, the status byte is unchanged.
- R10: Watchdog clear sets TO and PD. Sleep entry sets TO and clears PD. Watchdog expiry clears TO. No instruction ever changes TO or PD.
- R11: When events coincide, expiry wins over clear and sleep for TO, and sleep wins over clear for PD.
- R12: When dst_status is high the file operand is the current status byte and file_in is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_code | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| file_in | input | 8 | File operand, used when the destination is not the status byte |
| bit_idx | input | 3 | Bit index for bit set and bit clear |
| dst_status | input | 1 | The result is destined for the status byte |
| wdt_clear | input | 1 | Watchdog-clear event |
| sleep_enter | input | 1 | Sleep-entry event |
| wdt_expire | input | 1 | Watchdog-expiry event |
| result | output | 8 | Combinational operation result |
| status_q | output | 8 | Registered status byte |

## Verification
The main function is tried with directed operand pairs that separate the two carry chains. A nibble-only carry shows whether DC is taken from bit 3. A full wrap to zero tests Z and C together. Equal, smaller and nibble-borrowing subtractions pin down the inverted-borrow sense. A long random mix of all sixteen codes follows, with the status byte picked as destination about a quarter of the time and events injected sparsely. That mix separates flag-producing writes, which must be discarded, from plain writes, which must land, and it also confirms that an idle cycle holds every bit.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NIB  = 4;
  localparam int unsigned BIW  = $clog2(DW);
  localparam int unsigned OPW  = 4;

  localparam int unsigned C_POS  = 0;
  localparam int unsigned DC_POS = 1;
  localparam int unsigned Z_POS  = 2;
  localparam int unsigned PD_POS = 3;
  localparam int unsigned TO_POS = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CLR  = 4'd5,
    OP_RLC  = 4'd6,
    OP_RRC  = 4'd7,
    OP_BSET = 4'd8,
    OP_BCLR = 4'd9,
    OP_SWAP = 4'd10,
    OP_MOVW = 4'd11,
    OP_PS0  = 4'd12,
    OP_PS1  = 4'd13,
    OP_PS2  = 4'd14,
    OP_PS3  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/sr_flag_calc.sv
module sr_flag_calc
  import sr_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e                op,
  input  logic [W-1:0]           opa,
  input  logic [W-1:0]           opf,
  input  logic [$clog2(W)-1:0]   bidx,
  input  logic                   c_in,
  output logic [W-1:0]           res,
  output flags_t                 flg,
  output flags_t                 aff,
  output logic                   flag_op
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W:0]     sum;
  logic [NIB:0]   lsum;
  logic [W-1:0]   addend;
  logic           cin0;
  logic           rot_sel;
  logic           rot_c;
  logic [W-1:0]   bmask;

  // shared adder: subtract is file + ~acc + 1
  always_comb begin
    cin0   = (op == OP_SUB);
    addend = cin0 ? ~opa : opa;
    sum    = {1'b0, opf} + {1'b0, addend} + {{W{1'b0}}, cin0};
    lsum   = {1'b0, opf[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, cin0};
    bmask  = ONE << bidx;
  end

  always_comb begin
    res     = opf;
    aff     = '0;
    rot_sel = 1'b0;
    rot_c   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res = sum[W-1:0];
        aff = '{z: 1'b1, dc: 1'b1, c: 1'b1};
      end
      OP_AND: begin res = opa & opf; aff.z = 1'b1; end
      OP_OR:  begin res = opa | opf; aff.z = 1'b1; end
      OP_XOR: begin res = opa ^ opf; aff.z = 1'b1; end
      OP_CLR: begin res = '0;        aff.z = 1'b1; end
      OP_RLC: begin
        res     = {opf[W-2:0], c_in};
        aff.c   = 1'b1;
        rot_sel = 1'b1;
        rot_c   = opf[W-1];
      end
      OP_RRC: begin
        res     = {c_in, opf[W-1:1]};
        aff.c   = 1'b1;
        rot_sel = 1'b1;
        rot_c   = opf[0];
      end
      OP_BSET: res = opf | bmask;
      OP_BCLR: res = opf & ~bmask;
      OP_SWAP: res = {opf[NIB-1:0], opf[W-1:NIB]};
      OP_MOVW: res = opa;
      default: res = opf;
    endcase
    flag_op = |aff;
    flg.z   = ~|res;
    flg.dc  = lsum[NIB];
    flg.c   = rot_sel ? rot_c : sum[W];
  end
endmodule

// File: rtl/sr_flag_reg.sv
module sr_flag_reg
  import sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       flag_op,
  input  logic       dst_st,
  input  flags_t     aff,
  input  flags_t     flg,
  input  logic [2:0] wr_bits,
  output flags_t     q
);
  flags_t q_n;

  always_comb begin
    q_n = q;
    if (flag_op) begin
      if (aff.z)  q_n.z  = flg.z;
      if (aff.dc) q_n.dc = flg.dc;
      if (aff.c)  q_n.c  = flg.c;
    end else if (dst_st) begin
      q_n = flags_t'(wr_bits);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;
  end

  // R7: an idle cycle holds the arithmetic flags
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));

  // R8 / R6: a flag op that does not produce C cannot touch C, even through a status write
  a_r8_c_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag_op && !aff.c) |=> $stable(q.c));
endmodule

// File: rtl/sr_pwr_bits.sv
module sr_pwr_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slp,
  input  logic expire,
  output logic to_q,
  output logic pd_q
);
  logic ev;
  logic to_n;
  logic pd_n;

  always_comb begin
    ev   = clr | slp | expire;
    to_n = expire ? 1'b0 : 1'b1;
    pd_n = slp ? 1'b0 : (clr ? 1'b1 : pd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (ev) begin
      to_q <= to_n;
      pd_q <= pd_n;
    end
  end

  a_r10_no_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr || slp || expire) |=> ($stable(to_q) && $stable(pd_q)));

  a_r10_sleep_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (slp && !expire) |=> (to_q && !pd_q));

  a_r11_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !to_q);

  a_r11_sleep_over_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (slp && clr) |=> !pd_q);
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
  import sr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [7:0]  acc_in,
  input  logic [7:0]  file_in,
  input  logic [2:0]  bit_idx,
  input  logic        dst_status,
  input  logic        wdt_clear,
  input  logic        sleep_enter,
  input  logic        wdt_expire,
  output logic [7:0]  result,
  output logic [7:0]  status_q
);
  logic [1:0] rst_pipe;
  logic       rst_ns;
  alu_op_e    op_e;
  logic [DW-1:0] f_opnd;
  flags_t     flg;
  flags_t     aff;
  flags_t     fq;
  logic       flag_op;
  logic       to_q;
  logic       pd_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign op_e   = alu_op_e'(op_code);
  assign f_opnd = dst_status ? status_q : file_in;

  sr_flag_calc #(.W(DW)) u_calc (
    .op      (op_e),
    .opa     (acc_in),
    .opf     (f_opnd),
    .bidx    (bit_idx),
    .c_in    (fq.c),
    .res     (result),
    .flg     (flg),
    .aff     (aff),
    .flag_op (flag_op)
  );

  sr_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_ns),
    .en      (op_valid),
    .flag_op (flag_op),
    .dst_st  (dst_status),
    .aff     (aff),
    .flg     (flg),
    .wr_bits (result[2:0]),
    .q       (fq)
  );

  sr_pwr_bits u_pwr (
    .clk    (clk),
    .rst_n  (rst_ns),
    .clr    (wdt_clear),
    .slp    (sleep_enter),
    .expire (wdt_expire),
    .to_q   (to_q),
    .pd_q   (pd_q)
  );

  assign status_q = {3'b000, to_q, pd_q, fq.z, fq.dc, fq.c};

  a_r3_add_carry: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_e == OP_ADD) |=>
      status_q[C_POS] == $past(({1'b0, acc_in} + {1'b0, f_opnd}) > 9'd255));

  a_r4_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_e == OP_SUB) |=> status_q[C_POS] == $past(f_opnd >= acc_in));

  a_r5_rlc_carry: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && op_e == OP_RLC) |=> status_q[C_POS] == $past(f_opnd[DW-1]));

  a_r9_plain_write: assert property (@(posedge clk) disable iff (!rst_ns)
    (op_valid && dst_status && op_code[3]) |=> status_q[2:0] == $past(result[2:0]));
endmodule

// File: tb/sr_status_unit_tb.sv
module sr_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] acc_in;
  logic [7:0] file_in;
  logic [2:0] bit_idx;
  logic       dst_status;
  logic       wdt_clear;
  logic       sleep_enter;
  logic       wdt_expire;
  logic [7:0] result;
  logic [7:0] status_q;

  int n_vec = 0;
  int n_bad = 0;
  bit m_to, m_pd, m_z, m_dc, m_c;

  always #5 clk = ~clk;

  sr_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .file_in(file_in), .bit_idx(bit_idx),
    .dst_status(dst_status), .wdt_clear(wdt_clear), .sleep_enter(sleep_enter),
    .wdt_expire(wdt_expire), .result(result), .status_q(status_q)
  );

  function automatic logic [7:0] model_status();
    return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at a falling edge, check result, then status after the next rising edge
  task automatic step(input bit v, input int op, input int a, input int f, input int idx,
                      input bit dst, input bit clr, input bit slp, input bit expi,
                      input string tag);
    int fo, r;
    bit nz, ndc, nc, nto, npd;
    op_valid = v; op_code = op[3:0]; acc_in = a[7:0]; file_in = f[7:0];
    bit_idx = idx[2:0]; dst_status = dst; wdt_clear = clr; sleep_enter = slp;
    wdt_expire = expi;
    #1;
    fo = dst ? int'(model_status()) : (f & 255);
    a  = a & 255;
    nz = m_z; ndc = m_dc; nc = m_c;
    case (op)
      0: begin r = (fo + a) & 255; nc = (fo + a) > 255; ndc = ((fo % 16) + (a % 16)) > 15; end
      1: begin r = (fo - a + 256) & 255; nc = fo >= a; ndc = (fo % 16) >= (a % 16); end
      2: r = fo & a;
      3: r = fo | a;
      4: r = fo ^ a;
      5: r = 0;
      6: begin r = ((fo * 2) + int'(m_c)) & 255; nc = fo >= 128; end
      7: begin r = (fo / 2) + (m_c ? 128 : 0); nc = (fo % 2) == 1; end
      8: r = fo | (1 << (idx & 7));
      9: r = fo & ~(1 << (idx & 7)) & 255;
      10: r = ((fo % 16) * 16) + (fo / 16);
      11: r = a;
      default: r = fo;
    endcase
    if (op <= 5) nz = (r == 0);
    if (op >= 8 && dst) begin
      nz = r[2]; ndc = r[1]; nc = r[0];
    end
    if (!v) begin nz = m_z; ndc = m_dc; nc = m_c; end
    chk({tag, " result"}, result, r[7:0]);
    nto = m_to; npd = m_pd;
    if (expi) nto = 1'b0; else if (slp || clr) nto = 1'b1;
    if (slp) npd = 1'b0; else if (clr) npd = 1'b1;
    @(posedge clk);
    m_z = nz; m_dc = ndc; m_c = nc; m_to = nto; m_pd = npd;
    @(negedge clk);
    chk({tag, " status"}, status_q, model_status());
  endtask

  function automatic string tag_of(input bit v, input int op, input bit dst);
    if (!v) return "R7";
    if (dst) return (op <= 7) ? "R8" : "R9";
    case (op)
      0: return "R3";
      1: return "R4";
      6, 7: return "R5";
      2, 3, 4, 5: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; acc_in = '0; file_in = '0;
    bit_idx = '0; dst_status = 1'b0; wdt_clear = 1'b0; sleep_enter = 1'b0;
    wdt_expire = 1'b0;
    m_to = 1'b1; m_pd = 1'b1; m_z = 1'b0; m_dc = 1'b0; m_c = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", status_q, 8'h18);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", status_q, 8'h18);

    // R3 add
    step(1, 0, 8'h01, 8'h0F, 0, 0, 0, 0, 0, "R3 nibble carry");
    step(1, 0, 8'h01, 8'hFF, 0, 0, 0, 0, 0, "R3 wrap to zero");
    step(1, 0, 8'h80, 8'h80, 0, 0, 0, 0, 0, "R3 top carry only");
    // R4 subtract
    step(1, 1, 8'h05, 8'h05, 0, 0, 0, 0, 0, "R4 equal");
    step(1, 1, 8'h05, 8'h03, 0, 0, 0, 0, 0, "R4 borrow");
    step(1, 1, 8'h01, 8'h10, 0, 0, 0, 0, 0, "R4 nibble borrow");
    // R5 rotates
    step(1, 6, 0, 8'h80, 0, 0, 0, 0, 0, "R5 rlc");
    step(1, 7, 0, 8'h01, 0, 0, 0, 0, 0, "R5 rrc");
    step(1, 7, 0, 8'h02, 0, 0, 0, 0, 0, "R5 rrc carry in");
    // R6 logic keeps DC and C
    step(1, 0, 8'h0F, 8'hF1, 0, 0, 0, 0, 0, "R3 set carries");
    step(1, 2, 8'h0F, 8'hF0, 0, 0, 0, 0, 0, "R6 and zero");
    step(1, 3, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R6 or zero");
    step(1, 4, 8'hA5, 8'h5A, 0, 0, 0, 0, 0, "R6 xor");
    // R7 idle
    step(0, 0, 8'hFF, 8'hFF, 0, 0, 0, 0, 0, "R7 idle add");
    step(0, 5, 0, 0, 0, 1, 0, 0, 0, "R7 idle clear");
    // R8 flag op to status
    step(1, 5, 0, 8'hFF, 0, 1, 0, 0, 0, "R8 clear status");
    step(1, 0, 8'hFF, 0, 0, 1, 0, 0, 0, "R8 add to status");
    step(1, 2, 8'h00, 0, 0, 1, 0, 0, 0, "R8 and to status");
    // R9 plain writes
    step(1, 8, 0, 0, 0, 1, 0, 0, 0, "R9 bset c");
    step(1, 8, 0, 0, 4, 1, 0, 0, 0, "R9 bset to ignored");
    step(1, 9, 0, 0, 2, 1, 0, 0, 0, "R9 bclr z");
    step(1, 10, 0, 0, 0, 1, 0, 0, 0, "R9 swap");
    step(1, 11, 8'hFF, 0, 0, 1, 0, 0, 0, "R9 move ones");
    chk("R2 upper zero", status_q & 8'hE0, 8'h00);
    step(1, 11, 8'h00, 8'hFF, 0, 0, 0, 0, 0, "R9 move elsewhere");
    // R12 file_in ignored for status destination
    step(1, 12, 0, 8'hAA, 0, 1, 0, 0, 0, "R12 pass status");
    step(1, 8, 0, 8'h55, 1, 1, 0, 0, 0, "R12 bset status");
    // R10 / R11 events
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R10 sleep");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 wdt clear");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 expiry");
    step(1, 11, 8'hFF, 0, 0, 1, 0, 0, 0, "R10 write cannot set TO");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, "R11 expiry over clear");
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R11 sleep over clear");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R11 expiry with sleep");
    step(1, 5, 0, 0, 0, 1, 1, 0, 0, "R11 clear with instr");

    for (int i = 0; i < 3000; i++) begin
      int op;
      bit v, dst;
      op  = int'($urandom_range(0, 15));
      v   = ($urandom_range(0, 7) != 0);
      dst = ($urandom_range(0, 3) == 0);
      step(v, op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 7)), dst, ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
           tag_of(v, op, dst));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule